// File: doc/BRIEF.md
# System-control register unit with exception capture

This unit holds the three system-control registers of a small scalar core: a processor status word, an exception-reason word and a saved return address. The execute stage reaches them through one access port. The port is addressed by a 5-bit register index and a 3-bit select value. It supports a plain move-to, a plain move-from, and an atomic read-modify. The read-modify returns the old value and, on the same clock edge, forces bit 0 (the interrupt-enable bit) on or off.

When the pipeline raises an exception, the unit records a return address and the reason for the exception. If the faulting instruction was in a branch delay slot, the return address is the address of the branch or jump in front of it. Otherwise it is the address of the faulting instruction. When the core asks to return from an exception, the unit presents the saved address as the next fetch target in the same cycle. Registers are updated on the rising clock edge. Read data is combinational from the current register state.

Top module: `sysctl_regs`

## Requirements
- R1: After an active-low reset, the status register (index 12), the reason register (index 13) and the return-address register (index 14) all read as zero.
- R2: With `acc_op` = 1 (move-to) at index 12 or 14 and select 0, the register takes `acc_wdata` on the clock edge. A later move-from (`acc_op` = 2) returns that value.
- R3: The reason register keeps only bit 31 (delay-slot flag) and bits 6:2 (exception code). Every other bit always reads zero, including after a software write of all ones.
- R4: A move-from of any index other than 12, 13 or 14, or of any select other than 0, returns zero. A write to such an address changes no register.
- R5: An exception with the delay-slot flag low loads the return-address register with `exc_pc`.
- R6: An exception with the delay-slot flag high loads the return-address register with `exc_branch_pc`.
- R7: Every exception writes the reason register. Bits 6:2 take `exc_code`, and bit 31 takes the delay-slot flag, which is cleared when the flag is low.
- R8: A read-modify (`acc_op` = 3) with `acc_ie_set` high returns the old register value in the same cycle. On the edge, the register becomes that old value with bit 0 set.
- R9: A read-modify with `acc_ie_set` low returns the old value and leaves the register holding that old value with bit 0 cleared.
- R10: When an exception and a software write hit the reason or return-address register in the same cycle, the exception values are stored.
- R11: While `ret_req` is high, `ret_valid` is high and `ret_target` equals the current return-address register. Otherwise both outputs are zero.
- R12: `acc_rdata` is zero whenever `acc_op` is 0 (idle) or 1 (move-to).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_op | input | 2 | 0 idle, 1 move-to, 2 move-from, 3 read-modify |
| acc_reg | input | 5 | Register index |
| acc_sel | input | 3 | Register select |
| acc_wdata | input | 32 | Write data for move-to |
| acc_ie_set | input | 1 | Read-modify: 1 sets bit 0, 0 clears it |
| acc_rdata | output | 32 | Read data for move-from and read-modify |
| exc_valid | input | 1 | Exception strobe |
| exc_code | input | 5 | Exception code |
| exc_pc | input | 32 | Address of the faulting instruction |
| exc_branch_pc | input | 32 | Address of the preceding branch or jump |
| exc_in_slot | input | 1 | Faulting instruction sits in a delay slot |
| ret_req | input | 1 | Exception-return request |
| ret_valid | output | 1 | Return target is valid |
| ret_target | output | 32 | Next fetch address on return |

## Verification
The bound checker watches several rules on every cycle:
- the choice of return address between the faulting address and the branch address;
- the code and delay-slot fields of the reason register after each exception;
- that unused reason bits stay zero;
- that unmapped addresses read zero;
- that a move-to to the status register lands;
- that an interrupt-enable set lands;
- that an exception wins over a same-cycle software write.

Other effects can only be shown by the bench's ordered scenarios:
- that a write to an unmapped select leaves the real register untouched;
- that a read-modify returns the pre-modify value;
- that the return target follows a later software rewrite;
- that reset in the middle of a run clears state that was built up earlier.

// File: rtl/sysctl_pkg.sv
// Package: shared constants and the access-operation encoding for the
// system-control register unit. Assumes a 32-bit datapath and 5-bit codes.
package sysctl_pkg;

    localparam int XLEN_DEF   = 32;
    localparam int RIDX_W     = 5;
    localparam int SEL_W      = 3;
    localparam int CODE_W_DEF = 5;
    localparam int N_REGS     = 3;

    // Access operation presented by the execute stage
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2,
        ACC_RMW   = 2'd3
    } acc_op_e;

    // Slot numbers inside the unit
    localparam int SLOT_STATUS = 0;
    localparam int SLOT_CAUSE  = 1;
    localparam int SLOT_EPC    = 2;

    // Architectural index of each slot (select is always 0)
    function automatic logic [RIDX_W-1:0] slot_index(input int slot);
        case (slot)
            SLOT_STATUS: slot_index = 5'd12;
            SLOT_CAUSE:  slot_index = 5'd13;
            default:     slot_index = 5'd14;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
// Module: address and operation decoder.
// Turns the index/select pair into a one-hot slot hit and splits the
// operation into read and write enables. Assumes only select 0 is mapped.
module sysctl_decode
    import sysctl_pkg::*;
(
    input  logic [1:0]        op,
    input  logic [RIDX_W-1:0] ridx,
    input  logic [SEL_W-1:0]  rsel,
    output logic [N_REGS-1:0] hit,
    output logic              rd_en,
    output logic              wr_any,
    output logic              rmw
);

    // One comparator per mapped slot
    for (genvar g = 0; g < N_REGS; g++) begin : g_hit
        assign hit[g] = (ridx == slot_index(g)) && (rsel == '0);
    end

    // Operation split into read and write intent
    always_comb begin
        rd_en  = (op == ACC_READ) || (op == ACC_RMW);
        wr_any = (op == ACC_WRITE) || (op == ACC_RMW);
        rmw    = (op == ACC_RMW);
    end

endmodule

// File: rtl/sysctl_status.sv
// Module: status register.
// A plain software-writable word with a parameterised reset value.
// Assumes the caller has already merged any read-modify bit forcing.
module sysctl_status #(
    parameter int          XLEN = 32,
    parameter logic [31:0] RST  = 32'h0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] q
);

    // Register update with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= RST[XLEN-1:0];
        else if (we) q <= wdata;
    end

endmodule

// File: rtl/sysctl_trap_capture.sv
// Module: exception capture for the reason and return-address registers.
// The exception strobe overrides software writes in the same cycle.
// Assumes the delay-slot flag is valid whenever the strobe is high.
module sysctl_trap_capture #(
    parameter int XLEN   = 32,
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_valid,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [XLEN-1:0]   exc_pc,
    input  logic [XLEN-1:0]   exc_branch_pc,
    input  logic              exc_in_slot,
    input  logic              sw_cause_we,
    input  logic              sw_epc_we,
    input  logic [XLEN-1:0]   sw_wdata,
    output logic [XLEN-1:0]   cause_q,
    output logic [XLEN-1:0]   epc_q
);

    localparam int PAD_W    = XLEN - 3 - CODE_W;
    localparam int CODE_LSB = 2;
    localparam int CODE_MSB = CODE_LSB + CODE_W - 1;

    logic [XLEN-1:0] cause_hw;
    logic [XLEN-1:0] cause_sw;
    logic [XLEN-1:0] epc_hw;

    // Build the reason word from the exception inputs
    always_comb begin
        cause_hw = {exc_in_slot, {PAD_W{1'b0}}, exc_code, 2'b00};
        cause_sw = {sw_wdata[XLEN-1], {PAD_W{1'b0}}, sw_wdata[CODE_MSB:CODE_LSB], 2'b00};
        epc_hw   = exc_in_slot ? exc_branch_pc : exc_pc;
    end

    // Reason register: exception first, then software
    always_ff @(posedge clk) begin
        if (!rst_n)           cause_q <= '0;
        else if (exc_valid)   cause_q <= cause_hw;
        else if (sw_cause_we) cause_q <= cause_sw;
    end

    // Return-address register: exception first, then software
    always_ff @(posedge clk) begin
        if (!rst_n)         epc_q <= '0;
        else if (exc_valid) epc_q <= epc_hw;
        else if (sw_epc_we) epc_q <= sw_wdata;
    end

endmodule

// File: rtl/sysctl_regs.sv
// Module: system-control register unit (top).
// Joins the decoder, the status register and the exception capture,
// provides the read path, the read-modify merge and the return target.
// Assumes at most one access operation per cycle.
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int          XLEN       = 32,
    parameter int          CODE_W     = 5,
    parameter logic [31:0] STATUS_RST = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        acc_op,
    input  logic [4:0]        acc_reg,
    input  logic [2:0]        acc_sel,
    input  logic [XLEN-1:0]   acc_wdata,
    input  logic              acc_ie_set,
    output logic [XLEN-1:0]   acc_rdata,
    input  logic              exc_valid,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [XLEN-1:0]   exc_pc,
    input  logic [XLEN-1:0]   exc_branch_pc,
    input  logic              exc_in_slot,
    input  logic              ret_req,
    output logic              ret_valid,
    output logic [XLEN-1:0]   ret_target
);

    logic [N_REGS-1:0] hit;
    logic              rd_en;
    logic              wr_any;
    logic              rmw;
    logic [XLEN-1:0]   status_q;
    logic [XLEN-1:0]   cause_q;
    logic [XLEN-1:0]   epc_q;
    logic [XLEN-1:0]   slot_val [N_REGS];
    logic [XLEN-1:0]   sel_val;
    logic [XLEN-1:0]   wr_val;

    sysctl_decode i_dec (
        .op     (acc_op),
        .ridx   (acc_reg),
        .rsel   (acc_sel),
        .hit    (hit),
        .rd_en  (rd_en),
        .wr_any (wr_any),
        .rmw    (rmw)
    );

    sysctl_status #(.XLEN(XLEN), .RST(STATUS_RST)) i_status (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_any && hit[SLOT_STATUS]),
        .wdata (wr_val),
        .q     (status_q)
    );

    sysctl_trap_capture #(.XLEN(XLEN), .CODE_W(CODE_W)) i_trap (
        .clk           (clk),
        .rst_n         (rst_n),
        .exc_valid     (exc_valid),
        .exc_code      (exc_code),
        .exc_pc        (exc_pc),
        .exc_branch_pc (exc_branch_pc),
        .exc_in_slot   (exc_in_slot),
        .sw_cause_we   (wr_any && hit[SLOT_CAUSE]),
        .sw_epc_we     (wr_any && hit[SLOT_EPC]),
        .sw_wdata      (wr_val),
        .cause_q       (cause_q),
        .epc_q         (epc_q)
    );

    // Collect slot contents in slot order
    always_comb begin
        slot_val[SLOT_STATUS] = status_q;
        slot_val[SLOT_CAUSE]  = cause_q;
        slot_val[SLOT_EPC]    = epc_q;
    end

    // AND-OR read mux over the one-hot hit vector
    always_comb begin
        sel_val = '0;
        for (int i = 0; i < N_REGS; i++) begin
            sel_val = sel_val | (slot_val[i] & {XLEN{hit[i]}});
        end
    end

    // Read data is gated to zero unless a read is requested
    always_comb begin
        acc_rdata = rd_en ? sel_val : '0;
    end

    // Write value: plain data, or old value with bit 0 forced
    always_comb begin
        wr_val = acc_wdata;
        if (rmw) begin
            wr_val    = sel_val;
            wr_val[0] = acc_ie_set;
        end
    end

    // Exception-return target
    always_comb begin
        ret_valid  = ret_req;
        ret_target = ret_req ? epc_q : '0;
    end

endmodule

// File: rtl/sysctl_regs_chk.sv
// Module: protocol checker bound to sysctl_regs.
// Watches the register state against exception and access inputs.
module sysctl_regs_chk #(
    parameter int XLEN   = 32,
    parameter int CODE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        acc_op,
    input logic [4:0]        acc_reg,
    input logic [2:0]        acc_sel,
    input logic [XLEN-1:0]   acc_wdata,
    input logic              acc_ie_set,
    input logic [XLEN-1:0]   acc_rdata,
    input logic              exc_valid,
    input logic [CODE_W-1:0] exc_code,
    input logic [XLEN-1:0]   exc_pc,
    input logic [XLEN-1:0]   exc_branch_pc,
    input logic              exc_in_slot,
    input logic [XLEN-1:0]   status_q,
    input logic [XLEN-1:0]   cause_q,
    input logic [XLEN-1:0]   epc_q
);

    localparam logic [XLEN-1:0] KEEP = {1'b1, {(XLEN-3-CODE_W){1'b0}}, {CODE_W{1'b1}}, 2'b00};

    logic mapped;
    assign mapped = (acc_sel == 3'd0) && (acc_reg >= 5'd12) && (acc_reg <= 5'd14);

    assert_epc_plain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid && !exc_in_slot |=> epc_q == $past(exc_pc));

    assert_epc_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid && exc_in_slot |=> epc_q == $past(exc_branch_pc));

    assert_cause_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> (cause_q[CODE_W+1:2] == $past(exc_code)) && (cause_q[XLEN-1] == $past(exc_in_slot)));

    assert_cause_unused_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q & ~KEEP) == '0);

    assert_unmapped_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_op == 2'd2) && !mapped |-> acc_rdata == '0);

    assert_status_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_op == 2'd1) && (acc_reg == 5'd12) && (acc_sel == 3'd0) |=> status_q == $past(acc_wdata));

    assert_ie_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_op == 2'd3) && acc_ie_set && (acc_reg == 5'd12) && (acc_sel == 3'd0)
        |=> status_q == ($past(status_q) | {{(XLEN-1){1'b0}}, 1'b1}));

    assert_exc_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid && (acc_op == 2'd1) && (acc_reg == 5'd14) && (acc_sel == 3'd0)
        |=> epc_q == ($past(exc_in_slot) ? $past(exc_branch_pc) : $past(exc_pc)));

endmodule

bind sysctl_regs sysctl_regs_chk #(.XLEN(XLEN), .CODE_W(CODE_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_op        (acc_op),
    .acc_reg       (acc_reg),
    .acc_sel       (acc_sel),
    .acc_wdata     (acc_wdata),
    .acc_ie_set    (acc_ie_set),
    .acc_rdata     (acc_rdata),
    .exc_valid     (exc_valid),
    .exc_code      (exc_code),
    .exc_pc        (exc_pc),
    .exc_branch_pc (exc_branch_pc),
    .exc_in_slot   (exc_in_slot),
    .status_q      (status_q),
    .cause_q       (cause_q),
    .epc_q         (epc_q)
);

// File: tb/test_sysctl_regs.sv
`timescale 1ns/1ps
module test_sysctl_regs;

    typedef struct packed {
        logic [1:0]  op;
        logic [4:0]  ridx;
        logic [2:0]  rsel;
        logic [31:0] wd;
        logic        ie;
        logic        exv;
        logic [4:0]  code;
        logic [31:0] pc;
        logic [31:0] bpc;
        logic        slot;
        logic        ret;
        logic [31:0] exp_rd;
        logic [31:0] exp_tgt;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VECS [NV] = '{
        '{2'd2, 5'd12, 3'd0, 32'h0, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 8'd1},                   // R1
        '{2'd2, 5'd13, 3'd0, 32'h0, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 8'd1},                   // R1
        '{2'd2, 5'd14, 3'd0, 32'h0, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 8'd1},                   // R1
        '{2'd1, 5'd12, 3'd0, 32'hA5A50F0E, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 8'd12},           // R12
        '{2'd2, 5'd12, 3'd0, 32'h0, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0, 1'b0, 1'b0, 32'hA5A50F0E, 32'h0, 8'd2},            // R2
        '{2'd1, 5'd14, 3'd0, 32'h00400100, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 8'd12},           // R12
        '{2'd2, 5'd14, 3'd0, 32'h0, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h00400100, 32'h0, 8'd2},            // R2
        '{2'd1, 5'd13, 3'd0, 32'hFFFFFFFF, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 8'd3},            // R3
        '{2'd2, 5'd13, 3'd0, 32'h0, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h8000007C, 32'h0, 8'd3},            // R3
        '{2'd1, 5'd12, 3'd1, 32'h0, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 8'd4},                   // R4
        '{2'd2, 5'd12, 3'd0, 32'h0, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0, 1'b0, 1'b0, 32'hA5A50F0E, 32'h0, 8'd4},            // R4
        '{2'd2, 5'd12, 3'd1, 32'h0, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 8'd4},                   // R4
        '{2'd1, 5'd5,  3'd0, 32'h7B, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 8'd4},                  // R4
        '{2'd2, 5'd5,  3'd0, 32'h0, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 8'd4},                   // R4
        '{2'd0, 5'd12, 3'd0, 32'h0, 1'b0, 1'b1, 5'h0C, 32'h00400200, 32'h004001FC, 1'b0, 1'b0, 32'h0, 32'h0, 8'd12},   // R12
        '{2'd2, 5'd14, 3'd0, 32'h0, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h00400200, 32'h0, 8'd5},            // R5
        '{2'd2, 5'd13, 3'd0, 32'h0, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h00000030, 32'h0, 8'd7},            // R7
        '{2'd0, 5'd0,  3'd0, 32'h0, 1'b0, 1'b1, 5'h04, 32'h00400304, 32'h00400300, 1'b1, 1'b0, 32'h0, 32'h0, 8'd6},    // R6
        '{2'd2, 5'd14, 3'd0, 32'h0, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h00400300, 32'h0, 8'd6},            // R6
        '{2'd2, 5'd13, 3'd0, 32'h0, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h80000010, 32'h0, 8'd7},            // R7
        '{2'd3, 5'd12, 3'd0, 32'h0, 1'b1, 1'b0, 5'd0, 32'h0, 32'h0, 1'b0, 1'b0, 32'hA5A50F0E, 32'h0, 8'd8},            // R8
        '{2'd2, 5'd12, 3'd0, 32'h0, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0, 1'b0, 1'b0, 32'hA5A50F0F, 32'h0, 8'd8},            // R8
        '{2'd3, 5'd12, 3'd0, 32'h0, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0, 1'b0, 1'b0, 32'hA5A50F0F, 32'h0, 8'd9},            // R9
        '{2'd2, 5'd12, 3'd0, 32'h0, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0, 1'b0, 1'b0, 32'hA5A50F0E, 32'h0, 8'd9},            // R9
        '{2'd1, 5'd14, 3'd0, 32'h11111110, 1'b0, 1'b1, 5'h08, 32'h00400400, 32'h004003FC, 1'b0, 1'b0, 32'h0, 32'h0, 8'd10}, // R10
        '{2'd2, 5'd14, 3'd0, 32'h0, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h00400400, 32'h0, 8'd10},           // R10
        '{2'd1, 5'd13, 3'd0, 32'hFFFFFFFF, 1'b0, 1'b1, 5'h02, 32'h00400500, 32'h004004FC, 1'b0, 1'b0, 32'h0, 32'h0, 8'd10}, // R10
        '{2'd2, 5'd13, 3'd0, 32'h0, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h00000008, 32'h0, 8'd10},           // R10
        '{2'd0, 5'd0,  3'd0, 32'h0, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0, 1'b0, 1'b1, 32'h0, 32'h00400500, 8'd11},           // R11
        '{2'd1, 5'd14, 3'd0, 32'h00ABCDE0, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 8'd11},           // R11
        '{2'd2, 5'd14, 3'd0, 32'h0, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0, 1'b0, 1'b1, 32'h00ABCDE0, 32'h00ABCDE0, 8'd11}     // R11
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  acc_op = '0;
    logic [4:0]  acc_reg = '0;
    logic [2:0]  acc_sel = '0;
    logic [31:0] acc_wdata = '0;
    logic        acc_ie_set = 1'b0;
    logic [31:0] acc_rdata;
    logic        exc_valid = 1'b0;
    logic [4:0]  exc_code = '0;
    logic [31:0] exc_pc = '0;
    logic [31:0] exc_branch_pc = '0;
    logic        exc_in_slot = 1'b0;
    logic        ret_req = 1'b0;
    logic        ret_valid;
    logic [31:0] ret_target;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    sysctl_regs i_sysctl_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .acc_op        (acc_op),
        .acc_reg       (acc_reg),
        .acc_sel       (acc_sel),
        .acc_wdata     (acc_wdata),
        .acc_ie_set    (acc_ie_set),
        .acc_rdata     (acc_rdata),
        .exc_valid     (exc_valid),
        .exc_code      (exc_code),
        .exc_pc        (exc_pc),
        .exc_branch_pc (exc_branch_pc),
        .exc_in_slot   (exc_in_slot),
        .ret_req       (ret_req),
        .ret_valid     (ret_valid),
        .ret_target    (ret_target)
    );

    task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        acc_op = v.op; acc_reg = v.ridx; acc_sel = v.rsel; acc_wdata = v.wd; acc_ie_set = v.ie;
        exc_valid = v.exv; exc_code = v.code; exc_pc = v.pc; exc_branch_pc = v.bpc;
        exc_in_slot = v.slot; ret_req = v.ret;
    endtask

    task automatic read_reg(input int req, input logic [4:0] r, input logic [31:0] exp);
        drive('{2'd2, r, 3'd0, 32'h0, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 8'd0});
        #1;
        check(req, "read", acc_rdata, exp);
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (5000) @(posedge clk);
        n_fails++;
        $display("FAIL R0 watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            #1;
            check(int'(VECS[i].req), "rdata", acc_rdata, VECS[i].exp_rd);
            check(int'(VECS[i].req), "ret_valid", {31'h0, ret_valid}, {31'h0, VECS[i].ret});
            check(int'(VECS[i].req), "ret_target", ret_target, VECS[i].exp_tgt);
            @(negedge clk);
        end
        // R4: read-modify on an unmapped select reads zero and leaves status alone
        drive('{2'd3, 5'd12, 3'd2, 32'h0, 1'b1, 1'b0, 5'd0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 8'd4});
        #1;
        check(4, "rmw unmapped rdata", acc_rdata, 32'h0);
        @(negedge clk);
        read_reg(4, 5'd12, 32'hA5A50F0E);
        // R12: idle op on a mapped address returns zero
        drive('{2'd0, 5'd14, 3'd0, 32'h0, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 8'd12});
        #1;
        check(12, "idle rdata", acc_rdata, 32'h0);
        @(negedge clk);
        // R1: reset in mid-run clears built-up state
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        read_reg(1, 5'd12, 32'h0);
        read_reg(1, 5'd13, 32'h0);
        read_reg(1, 5'd14, 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule